// File: doc/BRIEF.md
# Pipelined Q1.15 Complex Multiplier

This block multiplies two complex numbers whose real and imaginary parts are 16-bit two's-complement fractions. Each part is read as a Q1.15 value. The block forms the four cross products. It then forms the real result as the difference of the like-part products and the imaginary result as the sum of the mixed products. Each result is scaled back to Q1.15 with rounding, and it is clamped to the 16-bit range when it does not fit.

A new operand pair can be accepted on every clock edge. The pipeline has three register stages: products, sum and difference, then scaling with the range check. A valid flag travels alongside the data. An overflow line rises together with any result that had to be clamped. The overflow line is not sticky, so each result carries its own flag.

Top module: `cmul_pipe`

## Requirements
- R1: `out_valid` equals the value of `in_valid` sampled three rising edges earlier, counting only edges where reset is low.
- R2: When it is representable, `y_re` equals `(a_re*b_re - a_im*b_im)` divided by 2^15 and rounded.
- R3: When it is representable, `y_im` equals `(a_re*b_im + a_im*b_re)` divided by 2^15 and rounded.
- R4: Rounding adds 2^14 to the full-width sum and then shifts it arithmetically right by 15 bits. Exact halves therefore go toward positive infinity: 1×16384 gives 1, and −1×16384 gives 0.
- R5: A result above +32767 becomes +32767, and a result below −32768 becomes −32768. The real and imaginary parts are clamped independently of each other.
- R6: `ovfl` is high in the same cycle as a valid result in which either part was clamped. Otherwise it is low, even if an earlier result overflowed.
- R7: `ovfl` is never high while `out_valid` is low.
- R8: A synchronous active-high `rst` clears every pipeline valid bit and `ovfl`. Work that was in flight when reset arrived never produces an output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands on the inputs are valid this cycle |
| a_re | input | 16 | Real part of first operand, Q1.15 |
| a_im | input | 16 | Imaginary part of first operand, Q1.15 |
| b_re | input | 16 | Real part of second operand, Q1.15 |
| b_im | input | 16 | Imaginary part of second operand, Q1.15 |
| out_valid | output | 1 | Result outputs hold a valid product |
| y_re | output | 16 | Real part of the product, Q1.15, saturated |
| y_im | output | 16 | Imaginary part of the product, Q1.15, saturated |
| ovfl | output | 1 | Either result part was clamped |

## Verification
Every result, together with its valid flag and overflow flag, is due exactly three rising edges after its operands were presented. The bench drives a new operand set at each falling edge. It also keeps a three-deep history of what it drove, and it compares the outputs at the falling edge against the entry driven three cycles earlier. In this way every comparison lands midway between the edge that produced the result and the edge that replaces it. The sweep covers all 4096 combinations of eight corner values, with `in_valid` dropped at regular intervals. A reset applied while the pipeline is full checks that the in-flight results are discarded.

// File: rtl/cmul_pipe.sv
module cmul_pipe #(
  parameter int W    = 16,
  parameter int FRAC = 15
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic signed [W-1:0] a_re,
  input  logic signed [W-1:0] a_im,
  input  logic signed [W-1:0] b_re,
  input  logic signed [W-1:0] b_im,
  output logic                out_valid,
  output logic signed [W-1:0] y_re,
  output logic signed [W-1:0] y_im,
  output logic                ovfl
);
  localparam int PW = 2 * W;
  localparam int SW = 2 * W + 1;
  localparam logic signed [SW-1:0] HALF = {{(SW-1){1'b0}}, 1'b1} << (FRAC - 1);
  localparam logic signed [SW-1:0] MAXV = {{(SW-W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [SW-1:0] MINV = {{(SW-W+1){1'b1}}, {(W-1){1'b0}}};
  localparam logic signed [W-1:0]  TOP  = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0]  BOT  = {1'b1, {(W-1){1'b0}}};

  logic v1, v2;
  logic signed [PW-1:0] p_ac, p_bd, p_ad, p_bc;
  logic signed [SW-1:0] s_re, s_im;

  always_ff @(posedge clk) begin
    p_ac <= a_re * b_re;
    p_bd <= a_im * b_im;
    p_ad <= a_re * b_im;
    p_bc <= a_im * b_re;
    s_re <= {p_ac[PW-1], p_ac} - {p_bd[PW-1], p_bd};
    s_im <= {p_ad[PW-1], p_ad} + {p_bc[PW-1], p_bc};
  end

  logic signed [SW-1:0] r_re, r_im;
  logic hi_re, lo_re, hi_im, lo_im;
  assign r_re  = (s_re + HALF) >>> FRAC;
  assign r_im  = (s_im + HALF) >>> FRAC;
  assign hi_re = r_re > MAXV;
  assign lo_re = r_re < MINV;
  assign hi_im = r_im > MAXV;
  assign lo_im = r_im < MINV;

  always_ff @(posedge clk) begin
    y_re <= hi_re ? TOP : lo_re ? BOT : r_re[W-1:0];
    y_im <= hi_im ? TOP : lo_im ? BOT : r_im[W-1:0];
    if (rst) begin
      v1        <= 1'b0;
      v2        <= 1'b0;
      out_valid <= 1'b0;
      ovfl      <= 1'b0;
    end else begin
      v1        <= in_valid;
      v2        <= v1;
      out_valid <= v2;
      ovfl      <= v2 & (hi_re | lo_re | hi_im | lo_im);
    end
  end

  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst)            age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  p_latency_r1: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  p_flag_needs_valid_r7: assert property (@(posedge clk) disable iff (rst)
    ovfl |-> out_valid);

  p_clamped_value_r5: assert property (@(posedge clk) disable iff (rst)
    ovfl |-> (y_re == TOP || y_re == BOT || y_im == TOP || y_im == BOT));

  p_reset_flush_r8: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd1) |-> (!out_valid && !ovfl));
endmodule

// File: tb/test_cmul_pipe.sv
module test_cmul_pipe;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [15:0] a_re = '0, a_im = '0, b_re = '0, b_im = '0;
  logic out_valid, ovfl;
  logic signed [15:0] y_re, y_im;

  cmul_pipe i_cmul_pipe (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
    .out_valid(out_valid), .y_re(y_re), .y_im(y_im), .ovfl(ovfl)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic h_v [3];
  logic signed [15:0] h_ar [3], h_ai [3], h_br [3], h_bi [3];

  function automatic logic signed [15:0] corner(int k);
    case (k)
      0: return -16'sd32768;
      1: return -16'sd32767;
      2: return -16'sd16384;
      3: return -16'sd1;
      4: return 16'sd0;
      5: return 16'sd1;
      6: return 16'sd16384;
      default: return 16'sd32767;
    endcase
  endfunction

  function automatic longint scale(longint s, output bit clamped);
    longint r;
    r = (s + 64'sd16384) >>> 15;
    clamped = 1'b0;
    if (r > 32767) begin r = 32767; clamped = 1'b1; end
    if (r < -32768) begin r = -32768; clamped = 1'b1; end
    return r;
  endfunction

  task automatic fail_line(string req, longint act, longint exp);
    failures++;
    $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
  endtask

  task automatic check_out();
    longint er, ei;
    bit cr, ci;
    checks++;
    if (h_v[2]) begin
      er = scale(longint'(h_ar[2]) * h_br[2] - longint'(h_ai[2]) * h_bi[2], cr);
      ei = scale(longint'(h_ar[2]) * h_bi[2] + longint'(h_ai[2]) * h_br[2], ci);
      if (out_valid !== 1'b1) fail_line("R1 out_valid", out_valid, 1);
      else if (y_re !== 16'(er)) fail_line("R2/R4/R5 y_re", y_re, er);
      else if (y_im !== 16'(ei)) fail_line("R3/R4/R5 y_im", y_im, ei);
      else if (ovfl !== (cr | ci)) fail_line("R6 ovfl", ovfl, cr | ci);
    end else begin
      if (out_valid !== 1'b0) fail_line("R1 out_valid", out_valid, 0);
      else if (ovfl !== 1'b0) fail_line("R7 ovfl", ovfl, 0);
    end
  endtask

  task automatic clear_hist();
    for (int i = 0; i < 3; i++) begin
      h_v[i] = 1'b0; h_ar[i] = '0; h_ai[i] = '0; h_br[i] = '0; h_bi[i] = '0;
    end
  endtask

  task automatic step(logic v, logic signed [15:0] ar, ai, br, bi);
    check_out();
    in_valid = v; a_re = ar; a_im = ai; b_re = br; b_im = bi;
    for (int i = 2; i > 0; i--) begin
      h_v[i] = h_v[i-1]; h_ar[i] = h_ar[i-1]; h_ai[i] = h_ai[i-1];
      h_br[i] = h_br[i-1]; h_bi[i] = h_bi[i-1];
    end
    h_v[0] = v; h_ar[0] = ar; h_ai[0] = ai; h_br[0] = br; h_bi[0] = bi;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    clear_hist();
    in_valid = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || ovfl !== 1'b0)
      fail_line("R8 reset state", {out_valid, ovfl}, 0);
    rst = 1'b0;
    in_valid = 1'b0;

    // R2 R3 R4 R5 R6: all corner combinations, with gaps in in_valid (R1 R7)
    for (int n = 0; n < 4096; n++)
      step((n % 7) != 3, corner(n & 7), corner((n >> 3) & 7),
           corner((n >> 6) & 7), corner((n >> 9) & 7));
    // R4: exact half cases
    step(1'b1, 16'sd1, 16'sd0, 16'sd16384, 16'sd0);
    step(1'b1, -16'sd1, 16'sd0, 16'sd16384, 16'sd0);
    step(1'b1, 16'sd3, 16'sd0, 16'sd16384, 16'sd0);
    repeat (4) step(1'b0, '0, '0, '0, '0);

    // R8: reset while the pipeline holds overflowing work
    for (int i = 0; i < 3; i++)
      step(1'b1, -16'sd32768, 16'sd0, -16'sd32768, 16'sd0);
    rst = 1'b1;
    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || ovfl !== 1'b0)
      fail_line("R8 flush", {out_valid, ovfl}, 0);
    rst = 1'b0;
    clear_hist();
    repeat (4) step(1'b0, '0, '0, '0, '0);
    step(1'b1, 16'sd16384, 16'sd16384, 16'sd16384, -16'sd16384);
    repeat (4) step(1'b0, '0, '0, '0, '0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule